// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer with Partial Readout

This block is the digital half of a successive-approximation converter. It drives a trial code into an external DAC and reads back one comparator decision per clock. Bits are resolved from the most significant bit down to the least significant bit. The analog sample-and-hold, the comparator and the DAC sit outside the block.

The result register is visible while the conversion is still running. Its upper bits are final and its lower, undecided bits read as zero. A valid-bit count says how many of the upper bits can be trusted. A one-cycle batch strobe fires each time a group of bits has been resolved, so a fast downstream controller can act on a coarse value before the full sample exists. A sticky done flag marks the end of the conversion. It is cleared by a write-one-to-clear input or by the next start.

Top module: `sar_seq`

## Requirements
- R1: After an accepted start, the trial code walks from bit RES_BITS-1 down to bit 0, one position per clock.
- R2: `cmp_i` is sampled on the clock edge that ends a trial. A 1 keeps the bit under trial as 1, and a 0 clears it to 0.
- R3: The trial code is the bits already decided, plus a 1 at the current position, plus zeros below it.
- R4: The result register changes by one decided bit per clock. Its undecided lower bits read as zero.
- R5: `valid_cnt_o` counts the decided upper bits. It is 0 right after start, rises by one per clock, and ends at RES_BITS.
- R6: `batch_stb_o` is high for exactly the cycle in which the valid count becomes a nonzero multiple of BATCH_BITS. At no other time during the conversion is it high.
- R7: When RES_BITS is not a multiple of BATCH_BITS, `batch_stb_o` also fires in the cycle in which the last bit resolves, together with the rise of `done_o`.
- R8: `done_o` rises in the cycle after the last comparison. It stays high until the next start or until `done_clr_i` is high at a clock edge.
- R9: A start accepted while idle clears the result, the valid count and the done flag. The MSB trial appears in the next cycle.
- R10: A start seen while a conversion is running has no effect on the trial code, the result, the count or the flags.
- R11: A synchronous reset returns the block to idle, with a zero trial code, a zero result, a zero count and both flags low.
- R12: While idle, including after completion, the trial code is zero and the result holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a conversion when idle |
| cmp_i | input | 1 | Comparator decision: 1 when the held input is at or above the trial level |
| done_clr_i | input | 1 | Write-one-to-clear for the done flag |
| dac_code_o | output | RES_BITS | Trial code for the DAC |
| result_o | output | RES_BITS | Partial or final result |
| valid_cnt_o | output | $clog2(RES_BITS+1) | Number of final upper bits in `result_o` |
| batch_stb_o | output | 1 | One-cycle pulse at each completed batch |
| done_o | output | 1 | Conversion-complete flag |

## Verification
Every output is registered. A stimulus applied before a clock edge therefore shows up right after that edge: the MSB trial one cycle after start, and the result bit, count, strobe and done one cycle after the matching comparator decision. The driver sets inputs on the falling edge and queues the expected outputs for the following rising edge. The monitor pops one item per cycle a short time after that rising edge, so every comparison lands in the first cycle in which the result is due. The expected trial codes and partial results come from a model of the held input, not from the design.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int DEF_RES_BITS   = 10;
    localparam int DEF_BATCH_BITS = 3;
endpackage

// File: rtl/sar_trial_gen.sv
module sar_trial_gen #(
    parameter int RES_BITS = 10,
    localparam int PW = $clog2(RES_BITS)
) (
    input  logic                busy_i,
    input  logic [PW-1:0]       pos_i,
    input  logic [RES_BITS-1:0] decided_i,
    output logic [RES_BITS-1:0] code_o
);
    // Each bit: decided value, or the trial 1 at the active position.
    for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
        assign code_o[i] = busy_i & (decided_i[i] | (pos_i == PW'(i)));
    end
endmodule

// File: rtl/sar_batch_track.sv
module sar_batch_track #(
    parameter int BATCH_BITS = 3,
    localparam int BW = (BATCH_BITS > 1) ? $clog2(BATCH_BITS) : 1
) (
    input  logic          advance_i,
    input  logic [BW-1:0] cnt_i,
    output logic [BW-1:0] cnt_o,
    output logic          hit_o
);
    always_comb begin
        cnt_o = cnt_i;
        hit_o = 1'b0;
        if (advance_i) begin
            if (cnt_i == BW'(BATCH_BITS - 1)) begin
                cnt_o = '0;
                hit_o = 1'b1;
            end else begin
                cnt_o = cnt_i + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
    parameter int RES_BITS   = sar_pkg::DEF_RES_BITS,
    parameter int BATCH_BITS = sar_pkg::DEF_BATCH_BITS,
    localparam int PW = $clog2(RES_BITS),
    localparam int VW = $clog2(RES_BITS + 1),
    localparam int BW = (BATCH_BITS > 1) ? $clog2(BATCH_BITS) : 1
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                start_i,
    input  logic                cmp_i,
    input  logic                done_clr_i,
    output logic [RES_BITS-1:0] dac_code_o,
    output logic [RES_BITS-1:0] result_o,
    output logic [VW-1:0]       valid_cnt_o,
    output logic                batch_stb_o,
    output logic                done_o
);
    typedef struct packed {
        logic                busy;
        logic [PW-1:0]       pos;
        logic [RES_BITS-1:0] result;
        logic [VW-1:0]       valid;
        logic [BW-1:0]       bcnt;
        logic                stb;
        logic                done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [BW-1:0] bcnt_next;
    logic          batch_hit;

    sar_batch_track #(.BATCH_BITS(BATCH_BITS)) u_batch (
        .advance_i (st_q.busy),
        .cnt_i     (st_q.bcnt),
        .cnt_o     (bcnt_next),
        .hit_o     (batch_hit)
    );

    sar_trial_gen #(.RES_BITS(RES_BITS)) u_trial (
        .busy_i    (st_q.busy),
        .pos_i     (st_q.pos),
        .decided_i (st_q.result),
        .code_o    (dac_code_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.stb  = 1'b0;
        st_d.done = st_q.done & ~done_clr_i;
        if (st_q.busy) begin
            st_d.result[st_q.pos] = cmp_i;
            st_d.valid            = st_q.valid + 1'b1;
            st_d.bcnt             = bcnt_next;
            if (st_q.pos == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.stb  = 1'b1;
            end else begin
                st_d.pos = st_q.pos - 1'b1;
                st_d.stb = batch_hit;
            end
        end else if (start_i) begin
            st_d.busy   = 1'b1;
            st_d.pos    = PW'(RES_BITS - 1);
            st_d.result = '0;
            st_d.valid  = '0;
            st_d.bcnt   = '0;
            st_d.done   = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o    = st_q.result;
    assign valid_cnt_o = st_q.valid;
    assign batch_stb_o = st_q.stb;
    assign done_o      = st_q.done;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int RES_BITS   = 10,
    parameter int BATCH_BITS = 3,
    localparam int VW = $clog2(RES_BITS + 1)
) (
    input logic                clk_i,
    input logic                rst_i,
    input logic                start_i,
    input logic                done_clr_i,
    input logic [RES_BITS-1:0] dac_code_o,
    input logic [RES_BITS-1:0] result_o,
    input logic [VW-1:0]       valid_cnt_o,
    input logic                batch_stb_o,
    input logic                done_o
);
    logic [RES_BITS-1:0] low_part;
    logic                mid_conv;
    assign low_part = RES_BITS'(result_o << valid_cnt_o);
    assign mid_conv = (valid_cnt_o != '0) && (valid_cnt_o != VW'(RES_BITS));

    // R5 / R10: the count climbs by one per clock mid-conversion, start or not
    a_r5_valid_step: assert property (@(posedge clk_i) disable iff (rst_i)
        mid_conv |=> (valid_cnt_o == VW'($past(valid_cnt_o) + 1'b1)));

    // R4: undecided lower bits read as zero
    a_r4_low_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_cnt_o != VW'(RES_BITS)) |-> (low_part == '0));

    // R6: strobe only on batch boundaries or at completion
    a_r6_stb_boundary: assert property (@(posedge clk_i) disable iff (rst_i)
        batch_stb_o |-> ((valid_cnt_o % VW'(BATCH_BITS)) == '0 || done_o));

    // R7: completion always brings a strobe
    a_r7_done_stb: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(done_o) |-> batch_stb_o);

    // R8: done is sticky without clear or start
    a_r8_done_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !done_clr_i && !start_i) |=> done_o);

    // R12: idle after completion gives a zero trial code
    a_r12_idle_dac: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_cnt_o == VW'(RES_BITS)) |-> (dac_code_o == '0));
endmodule

bind sar_seq sar_seq_chk #(.RES_BITS(RES_BITS), .BATCH_BITS(BATCH_BITS)) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .done_clr_i  (done_clr_i),
    .dac_code_o  (dac_code_o),
    .result_o    (result_o),
    .valid_cnt_o (valid_cnt_o),
    .batch_stb_o (batch_stb_o),
    .done_o      (done_o)
);

// File: tb/sim_sar_seq.sv
`timescale 1ns/1ps
module sim_sar_seq;
    localparam int RES = 10;
    localparam int BAT = 3;
    localparam int VW  = $clog2(RES + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, cmp_i = 1'b0, done_clr_i = 1'b0;
    logic [RES-1:0] dac_code_o, result_o;
    logic [VW-1:0]  valid_cnt_o;
    logic batch_stb_o, done_o;

    always #2.5 clk = ~clk;

    sar_seq #(.RES_BITS(RES), .BATCH_BITS(BAT)) u0 (
        .clk_i(clk), .rst_i(rst), .start_i(start_i), .cmp_i(cmp_i),
        .done_clr_i(done_clr_i), .dac_code_o(dac_code_o), .result_o(result_o),
        .valid_cnt_o(valid_cnt_o), .batch_stb_o(batch_stb_o), .done_o(done_o)
    );

    typedef struct {
        int    dac;
        int    res;
        int    vld;
        int    stb;
        int    dn;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit finished = 0;

    function automatic int top_bits(int v, int k);
        if (k <= 0) return 0;
        return v & ~((1 << (RES - k)) - 1);
    endfunction

    function automatic int trial(int v, int k);
        if (k >= RES) return 0;
        return top_bits(v, k) | (1 << (RES - 1 - k));
    endfunction

    function automatic int stb_at(int k);
        return (k > 0 && ((k % BAT) == 0 || k == RES)) ? 1 : 0;
    endfunction

    task automatic push(int dac, int res, int vld, int stb, int dn, string tag);
        exp_t e;
        e.dac = dac; e.res = res; e.vld = vld; e.stb = stb; e.dn = dn; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: one expected item per cycle, sampled after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (int'(dac_code_o) != e.dac || int'(result_o) != e.res ||
                    int'(valid_cnt_o) != e.vld || int'(batch_stb_o) != e.stb ||
                    int'(done_o) != e.dn) begin
                    failures++;
                    $display("FAIL %s: dac=%h res=%h vld=%0d stb=%0d done=%0d exp dac=%h res=%h vld=%0d stb=%0d done=%0d",
                             e.tag, dac_code_o, result_o, valid_cnt_o, batch_stb_o, done_o,
                             e.dac, e.res, e.vld, e.stb, e.dn);
                end
            end
        end
    end

    // Driver: runs nsteps comparisons; a spurious start at step spur (R10)
    task automatic convert(int vin, int nsteps, int spur);
        @(negedge clk);
        start_i = 1'b1; cmp_i = 1'b0;
        push(trial(vin, 0), 0, 0, 0, 0, "R9 start/MSB trial R1");
        for (int k = 0; k < nsteps; k++) begin
            @(negedge clk);
            start_i = (k == spur);
            cmp_i   = (vin >= trial(vin, k));
            push(trial(vin, k + 1), top_bits(vin, k + 1), k + 1, stb_at(k + 1),
                 (k + 1 == RES) ? 1 : 0,
                 (k == spur) ? "R10 start ignored" : "R1 R2 R3 R4 R5 R6 R7 R8");
        end
    endtask

    task automatic idle_hold(int vin, int dn, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i = 1'b0; cmp_i = 1'b1; done_clr_i = 1'b0;
            push(0, vin, RES, 0, dn, "R12 idle hold / R8 sticky done");
        end
    endtask

    initial begin
        // R11: reset state
        @(negedge clk);
        push(0, 0, 0, 0, 0, "R11 reset");
        @(negedge clk);
        rst = 1'b0;
        push(0, 0, 0, 0, 0, "R11 idle after reset R12");

        convert('h2A5, RES, -1);
        idle_hold('h2A5, 1, 3);

        // R8: write-one-to-clear
        @(negedge clk);
        done_clr_i = 1'b1;
        push(0, 'h2A5, RES, 0, 0, "R8 done clear");
        @(negedge clk);
        done_clr_i = 1'b0;
        push(0, 'h2A5, RES, 0, 0, "R8 stays clear");

        convert('h3FF, RES, -1);
        idle_hold('h3FF, 1, 2);

        // R9: start while done clears everything
        convert(0, RES, -1);
        idle_hold(0, 1, 1);

        convert('h155, RES, 4);
        idle_hold('h155, 1, 1);

        convert('h200, RES, 8);
        idle_hold('h200, 1, 1);

        // R11: reset mid-conversion
        convert('h1C3, 5, -1);
        @(negedge clk);
        rst = 1'b1; start_i = 1'b0;
        push(0, 0, 0, 0, 0, "R11 reset mid-conversion");
        @(negedge clk);
        rst = 1'b0;
        push(0, 0, 0, 0, 0, "R11 idle after reset");

        convert('h0FF, RES, -1);
        idle_hold('h0FF, 1, 2);

        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule